// File: doc/BRIEF.md
# Multi-channel general-purpose timer bank

The block holds six independent timer channels behind a plain word-addressed register port: a write strobe, a byte address, 32-bit write data and a combinational read path. Each channel has an up-counter that moves only on ticks of a clock source chosen per channel. The source is either a fast system tick or a slow low-frequency tick, and the count may be halved by a divide-by-two option. The counter is compared against a programmable value.

A channel runs in one of three modes. In one-shot mode it stops itself on a match. In repeat mode it restarts from zero on each match and keeps counting. In free-running mode it ignores the compare value and wraps. Every match sets a per-channel pending flag. A global mask register selects which pending flags can drive the single interrupt line. A write-one-to-clear acknowledge register drops pending flags. Software typically uses one channel as a free-running time base and another as a one-shot or periodic event source.

Top module: `gpt_bank`

## Requirements
- R1: Address bits 1:0 are ignored. Channel n (1..NUM_CH) decodes four registers at byte offsets 0x10·n (control), 0x10·n+0x04 (clock setup), 0x10·n+0x08 (counter) and 0x10·n+0x0C (compare). The interrupt mask sits at 0x00. The acknowledge register sits at 0x08 and reads back the pending flags. Channel n owns bit n−1 of both global registers. Every register reads 0 after reset. Counter and compare are CNT_W bits wide and read with zero upper bits. Unmapped addresses read 0.
- R2: In the control word, bit 0 is the run enable and bits 5:4 are the mode: 0 one-shot, 1 repeat, 2 one-shot, 3 free-running. Bit 1 is a clear strobe: a control write with bit 1 set zeroes the counter at the clock edge of the write, and bit 1 always reads back as 0.
- R3: In the clock setup word, bit 4 picks the source: 0 is the fast tick and 1 is the slow tick. Bits 3:0 equal to 1 make the counter advance on every second tick of that source, counted from the last clear. Any other value of bits 3:0 advances the counter on every tick. Ticks of the source that is not selected have no effect.
- R4: A channel whose enable bit is 0 holds its count. Clearing only the enable bit with a read-modify-write stops the channel and leaves the mode field unchanged.
- R5: In one-shot mode, an advance that brings the count to the compare value sets the channel's pending flag and clears its enable bit, so the counter rests at the compare value.
- R6: In repeat mode, an advance that would bring the count to the compare value instead sets the pending flag and returns the counter to 0, with the channel still enabled. With compare value C, the count after M advances from clear is M mod C.
- R7: In free-running mode, the counter wraps modulo 2^CNT_W and never sets the pending flag, whatever the compare value.
- R8: A pending flag sets even when its mask bit is 0. The interrupt output is high exactly when some channel has both its pending flag and its mask bit set.
- R9: Writing the acknowledge register clears the pending flags whose bits are 1 and leaves the others. When an acknowledge and a new match of the same channel fall in the same cycle, the flag stays set.
- R10: Writes to a counter register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_tick | input | 1 | Count enable of the fast source |
| slow_tick | input | 1 | Count enable of the slow source |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Combined masked interrupt |

## Verification
The register map is tried with a distinct pattern per channel and field, with out-of-range upper bits set. This separates a channel-decode slip from a field-position or masking error. The counting path is swept over every channel, both sources and both divider settings while the unselected source ticks in between, which tells a wrong source pick from a wrong divide ratio. One-shot is swept over compare values 1 to 6 in modes 0 and 2, and repeat over 1 to 9 advances against compare 4, so off-by-one match points and a missing restart both show as wrong counts. A 300-tick free run against a small compare value checks the wrap and that no flag is raised, and timed acknowledge writes separate the mask, the per-bit clear and the match-over-acknowledge priority.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        MODE_ONCE   = 2'd0,
        MODE_REPEAT = 2'd1,
        MODE_ONCE2  = 2'd2,
        MODE_FREE   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_CLK   = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_CMP   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic  run;
        mode_e mode;
    } ctrl_t;

    typedef struct packed {
        logic       slow;
        logic [3:0] div;
    } clkcfg_t;

    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_CLEAR_BIT = 1;
    localparam int DIV_HALF_CODE  = 1;

    function automatic logic [31:0] ctrl_word(ctrl_t c);
        return {26'd0, c.mode, 3'b000, c.run};
    endfunction

    function automatic logic [31:0] clk_word(clkcfg_t c);
        return {27'd0, c.slow, c.div};
    endfunction

    function automatic logic div_is_half(logic [3:0] d);
        return d == 4'(DIV_HALF_CODE);
    endfunction

    function automatic logic stops_on_match(mode_e m);
        return (m == MODE_ONCE) || (m == MODE_ONCE2);
    endfunction

endpackage

// File: rtl/gpt_decode.sv
module gpt_decode
    import gpt_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              glb_hit,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_sel_e          sel
);
    localparam int IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_lsb;

    assign idx        = addr[ADDR_W-1:4];
    assign sel        = reg_sel_e'(addr[3:2]);
    assign glb_hit    = (idx == '0);
    assign unused_lsb = addr[1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign ch_hit[i] = (idx == IDX_W'(i + 1));
    end
endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
    import gpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fast_tick,
    input  logic             slow_tick,
    input  logic             wr_ctrl,
    input  logic             wr_clk,
    input  logic             wr_cmp,
    input  logic [31:0]      wdata,
    input  reg_sel_e         rd_sel,
    output logic [31:0]      rd_word,
    output logic             run_o,
    output logic [1:0]       mode_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);
    ctrl_t            ctrl_q;
    clkcfg_t          cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             phase_q;

    logic             tick;
    logic             half;
    logic             advance;
    logic             hit;
    logic             clear_req;
    logic [CNT_W-1:0] cnt_next;

    assign tick      = cfg_q.slow ? slow_tick : fast_tick;
    assign half      = div_is_half(cfg_q.div);
    assign advance   = ctrl_q.run && tick && (!half || phase_q);
    assign cnt_next  = cnt_q + 1'b1;
    assign hit       = advance && (ctrl_q.mode != MODE_FREE) && (cnt_next == cmp_q);
    assign clear_req = wr_ctrl && wdata[CTRL_CLEAR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            cfg_q   <= '0;
            cnt_q   <= '0;
            cmp_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            if (clear_req) begin
                phase_q <= 1'b0;
            end else if (ctrl_q.run && tick && half) begin
                phase_q <= ~phase_q;
            end

            if (wr_ctrl) begin
                ctrl_q.run  <= wdata[CTRL_RUN_BIT];
                ctrl_q.mode <= mode_e'(wdata[5:4]);
            end else if (hit && stops_on_match(ctrl_q.mode)) begin
                ctrl_q.run <= 1'b0;
            end

            if (clear_req) begin
                cnt_q <= '0;
            end else if (hit && ctrl_q.mode == MODE_REPEAT) begin
                cnt_q <= '0;
            end else if (advance) begin
                cnt_q <= cnt_next;
            end

            if (wr_clk) begin
                cfg_q.slow <= wdata[4];
                cfg_q.div  <= wdata[3:0];
            end

            if (wr_cmp) begin
                cmp_q <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_CTRL:  rd_word = ctrl_word(ctrl_q);
            SEL_CLK:   rd_word = clk_word(cfg_q);
            SEL_COUNT: rd_word = 32'(cnt_q);
            SEL_CMP:   rd_word = 32'(cmp_q);
            default:   rd_word = '0;
        endcase
    end

    assign run_o   = ctrl_q.run;
    assign mode_o  = ctrl_q.mode;
    assign cnt_o   = cnt_q;
    assign match_o = hit;
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mask,
    input  logic              wr_ack,
    input  logic [31:0]       wdata,
    input  logic [NUM_CH-1:0] match,
    output logic [NUM_CH-1:0] pend_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] ack_bits;
    logic              unused_hi;

    assign ack_bits  = wr_ack ? wdata[NUM_CH-1:0] : '0;
    assign unused_hi = ^wdata[31:NUM_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_bits) | match;
            if (wr_mask) begin
                mask_q <= wdata[NUM_CH-1:0];
            end
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign irq_o  = |(pend_q & mask_q);
endmodule

// File: rtl/gpt_bank.sv
module gpt_bank
    import gpt_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    localparam int SPAN = (NUM_CH + 1) * 16;

    initial begin
        if (SPAN > (1 << ADDR_W)) $error("address width too small for channel count");
        if (CNT_W > 32 || NUM_CH > 32) $error("width exceeds data bus");
    end

    logic                         glb_hit;
    logic [NUM_CH-1:0]            ch_hit;
    reg_sel_e                     sel;
    logic [NUM_CH-1:0]            ch_wr_ctrl;
    logic [NUM_CH-1:0]            ch_en;
    logic [NUM_CH-1:0][1:0]       ch_mode;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
    logic [NUM_CH-1:0][31:0]      ch_rd;
    logic [NUM_CH-1:0]            ch_match;
    logic [NUM_CH-1:0]            pend_q;
    logic [NUM_CH-1:0]            ien_q;

    gpt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr    (addr),
        .glb_hit (glb_hit),
        .ch_hit  (ch_hit),
        .sel     (sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_wr_ctrl[i] = wr_en && ch_hit[i] && (sel == SEL_CTRL);

        gpt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .fast_tick (fast_tick),
            .slow_tick (slow_tick),
            .wr_ctrl   (ch_wr_ctrl[i]),
            .wr_clk    (wr_en && ch_hit[i] && (sel == SEL_CLK)),
            .wr_cmp    (wr_en && ch_hit[i] && (sel == SEL_CMP)),
            .wdata     (wdata),
            .rd_sel    (sel),
            .rd_word   (ch_rd[i]),
            .run_o     (ch_en[i]),
            .mode_o    (ch_mode[i]),
            .cnt_o     (ch_cnt[i]),
            .match_o   (ch_match[i])
        );
    end

    gpt_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr_mask (wr_en && glb_hit && (sel == SEL_CTRL)),
        .wr_ack  (wr_en && glb_hit && (sel == SEL_COUNT)),
        .wdata   (wdata),
        .match   (ch_match),
        .pend_o  (pend_q),
        .mask_o  (ien_q),
        .irq_o   (irq)
    );

    always_comb begin
        rdata = '0;
        if (glb_hit) begin
            if (sel == SEL_CTRL)  rdata = 32'(ien_q);
            if (sel == SEL_COUNT) rdata = 32'(pend_q);
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) rdata = ch_rd[i];
        end
    end
endmodule

// File: rtl/gpt_bank_chk.sv
module gpt_bank_chk #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic [31:0]                  wdata,
    input logic                         irq,
    input logic [NUM_CH-1:0]            ch_wr_ctrl,
    input logic [NUM_CH-1:0]            ch_en,
    input logic [NUM_CH-1:0][1:0]       ch_mode,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0]            pend_q,
    input logic [NUM_CH-1:0]            ien_q
);
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
            (ch_wr_ctrl[k] && wdata[1]) |=> (ch_cnt[k] == '0));

        p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
            (!ch_en[k] && !ch_wr_ctrl[k]) |=> (ch_cnt[k] == $past(ch_cnt[k])));

        p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> ((ch_cnt[k] == $past(ch_cnt[k])) ||
                      (ch_cnt[k] == CNT_W'($past(ch_cnt[k]) + 1'b1)) ||
                      (ch_cnt[k] == '0)));

        p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (rst)
            ($rose(pend_q[k]) && !$past(ch_wr_ctrl[k]) &&
             (ch_mode[k] == 2'd0 || ch_mode[k] == 2'd2)) |-> !ch_en[k]);

        p_free_silent_r7: assert property (@(posedge clk) disable iff (rst)
            ($rose(pend_q[k]) && !$past(ch_wr_ctrl[k])) |-> (ch_mode[k] != 2'd3));
    end
endmodule

bind gpt_bank gpt_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpt_bank_tb.sv
module gpt_bank_tb;
    localparam int CLK_P  = 10;
    localparam int NCH    = 6;
    localparam int CW     = 8;
    localparam int AW     = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fast_tick = 1'b0;
    logic          slow_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    gpt_bank #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        addr = AW'(a);
        #1 d = rdata;
    endtask

    task automatic ticks(int n, bit f, bit s);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fast_tick = f; slow_tick = s;
            @(negedge clk);
            fast_tick = 1'b0; slow_tick = 1'b0;
        end
    endtask

    function automatic int a_ctl(int n); return 16 * n; endfunction
    function automatic int a_clk(int n); return 16 * n + 4; endfunction
    function automatic int a_cnt(int n); return 16 * n + 8; endfunction
    function automatic int a_cmp(int n); return 16 * n + 12; endfunction

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every register
        rd(0, v); chk("R1 mask reset", v, 0);
        rd(8, v); chk("R1 pending reset", v, 0);
        for (int n = 1; n <= NCH; n++) begin
            for (int r = 0; r < 4; r++) begin
                rd(16 * n + 4 * r, v); chk("R1 channel reg reset", v, 0);
            end
        end
        chk("R8 irq reset", 32'(irq), 0);

        // R1/R2: distinct pattern per channel, clear bit and upper bits dropped
        for (int n = 1; n <= NCH; n++) begin
            wr(a_ctl(n), 32'((n % 4) << 4) | 32'h2);
            wr(a_clk(n), 32'hFFFF_FF00 | 32'(((n & 1) << 4) | n));
            wr(a_cmp(n), 32'hFFFF_FF00 | 32'(8'hA0 + n));
        end
        for (int n = 1; n <= NCH; n++) begin
            rd(a_ctl(n), v); chk("R2 ctrl readback, clear reads 0", v, 32'((n % 4) << 4));
            rd(a_clk(n), v); chk("R1 clock setup readback", v, 32'(((n & 1) << 4) | n));
            rd(a_cmp(n), v); chk("R1 compare readback", v, 32'(8'hA0 + n));
            rd(a_cnt(n), v); chk("R1 counter idle", v, 0);
        end
        rd(16 * (NCH + 1), v); chk("R1 unmapped reads 0", v, 0);
        wr(0, 32'h2A); rd(0, v); chk("R1 mask readback", v, 32'h2A);
        wr(0, 0);

        // R10: counter writes ignored
        wr(a_cnt(3), 32'h55); rd(a_cnt(3), v); chk("R10 counter write ignored", v, 0);

        // R3: every channel, both sources, both dividers, foreign ticks interleaved
        for (int n = 1; n <= NCH; n++) begin
            for (int s = 0; s < 2; s++) begin
                for (int d = 0; d < 2; d++) begin
                    wr(a_clk(n), 32'((s << 4) | d));
                    wr(a_ctl(n), 32'h33);
                    ticks(3, s == 1, s == 0);
                    ticks(5, s == 0, s == 1);
                    ticks(2, s == 1, s == 0);
                    rd(a_cnt(n), v); chk("R3 source and divider", v, 32'(5 >> d));
                    wr(a_ctl(n), 32'h30);
                end
            end
            wr(a_clk(n), 0);
        end

        // R4: read-modify-write stop holds count and mode
        wr(a_ctl(2), 32'h33);
        ticks(4, 1, 0);
        rd(a_ctl(2), v);
        wr(a_ctl(2), v & ~32'h1);
        ticks(6, 1, 1);
        rd(a_cnt(2), v); chk("R4 stopped count held", v, 4);
        rd(a_ctl(2), v); chk("R4 mode kept after stop", v, 32'h30);

        // R2: clear strobe zeroes a stopped counter
        wr(a_ctl(2), 32'h32);
        rd(a_cnt(2), v); chk("R2 clear zeroes counter", v, 0);

        // R5: one-shot sweep over compare and both one-shot codes
        for (int m = 0; m <= 2; m += 2) begin
            for (int c = 1; c <= 6; c++) begin
                wr(8, 32'h3F);
                wr(a_cmp(1), 32'(c));
                wr(a_ctl(1), 32'((m << 4) | 3));
                ticks(10, 1, 0);
                rd(a_cnt(1), v); chk("R5 one-shot rests at compare", v, 32'(c));
                rd(a_ctl(1), v); chk("R5 one-shot clears enable", v, 32'(m << 4));
                rd(8, v); chk("R5 one-shot sets pending", v & 1, 1);
            end
        end

        // R6: repeat restarts at zero
        wr(a_cmp(1), 4);
        for (int mm = 1; mm <= 9; mm++) begin
            wr(8, 32'h3F);
            wr(a_ctl(1), 32'h13);
            ticks(mm, 1, 0);
            rd(a_cnt(1), v); chk("R6 repeat count", v, 32'(mm % 4));
            rd(8, v); chk("R6 repeat pending", v & 1, (mm >= 4) ? 1 : 0);
            rd(a_ctl(1), v); chk("R6 repeat stays enabled", v, 32'h11);
        end
        wr(a_ctl(1), 32'h10);

        // R7: free-running wraps and never flags
        wr(8, 32'h3F);
        wr(a_cmp(1), 3);
        wr(a_ctl(1), 32'h33);
        ticks(300, 1, 0);
        rd(a_cnt(1), v); chk("R7 free-running wrap", v, 32'(300 % 256));
        rd(8, v); chk("R7 free-running no pending", v, 0);
        wr(a_ctl(1), 32'h30);

        // R8: masked pending, interrupt combine
        wr(0, 0);
        wr(8, 32'h3F);
        wr(a_cmp(2), 2);
        wr(a_ctl(2), 32'h03);
        ticks(3, 1, 0);
        rd(8, v); chk("R8 pending while masked", v, 32'h02);
        chk("R8 irq low while masked", 32'(irq), 0);
        wr(0, 32'h04);
        @(negedge clk); chk("R8 other mask bit", 32'(irq), 0);
        wr(0, 32'h02);
        @(negedge clk); chk("R8 irq high when unmasked", 32'(irq), 1);

        // R9: per-bit acknowledge
        wr(8, 32'h01);
        @(negedge clk); chk("R9 ack of other bit keeps irq", 32'(irq), 1);
        wr(8, 32'h02);
        @(negedge clk); chk("R9 ack clears irq", 32'(irq), 0);

        // R9: match beats acknowledge in the same cycle
        wr(8, 32'h3F);
        wr(a_cmp(1), 3);
        wr(a_ctl(1), 32'h13);
        ticks(2, 1, 0);
        rd(8, v); chk("R9 no pending before match", v, 0);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(8); wdata = 32'h01; fast_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; fast_tick = 1'b0;
        rd(8, v); chk("R9 match wins over ack", v, 32'h01);
        wr(8, 32'h01);
        rd(8, v); chk("R9 plain ack clears", v, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule